// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a single asynchronous serial line into characters. The line is first re-timed through a synchroniser. A falling edge starts a frame. The receiver then waits half a bit time, confirms that the line is still low, and samples every following bit at its centre, one full bit time apart.

When a character is complete, the block raises a one-cycle strobe. In that cycle it presents the data byte, a parity-error flag and a framing-error flag. A frame in which every sample is low, including the first stop position, is reported as a line break instead of a character.

The frame format comes from a 30-bit run-time setup word. The fields are:
- bits [23:0]: system clocks per bit time.
- bits [29:28]: word length code.
- bit 27: stop-bit count.
- bits 26, 25 and 24: parity control.

The block captures the setup word only while it waits for a start edge. Changes made during a frame therefore take effect from the next character. After reset the receiver must see a long idle stretch before it accepts anything.

Top module: `serial_rx_core`

## Requirements
- R1: While `rst_n` is sampled low (synchronous reset), `char_valid` and `line_break` become 0 and `line_sync` becomes 1.
- R2: `line_sync` equals `line_in` delayed by exactly two clock edges, and all receive logic uses only this re-timed copy.
- R3: Setup bits [23:0] give the clocks per bit time. With bits [29:24] zero (8 data bits, no parity, one stop bit), a frame is start bit 0, eight data bits least-significant first, then stop bit 1, and the byte appears on `char_data`.
- R4: Setup bits [29:28] choose the word length: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. A shorter word appears in the low bits of `char_data`, with the upper bits zero.
- R5: Setup bit 26 enables a parity bit after the data. Bits 25 and 24 choose its rule: 00 odd, 01 even, 10 always 0, 11 always 1. `parity_err` is 1 with the strobe when the received parity bit breaks the rule, and 0 when parity is off.
- R6: `frame_err` is 1 with the strobe when a stop bit is sampled low. Setup bit 27 set means two stop bits, and both are checked.
- R7: `char_valid` is high for exactly one clock per character.
- R8: The setup word is captured only while the receiver is idle. A change made during a frame does not alter that frame's decoding.
- R9: After reset, no start bit is accepted until the line has been high for 16 consecutive bit times.
- R10: A low pulse that has ended by the half-bit check is discarded without a strobe, and the receiver goes back to waiting for a start edge.
- R11: If the line is low at every sample from the start bit through the first stop position, `line_break` goes to 1 and no strobe is issued. `line_break` returns to 0 once the line is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| setup_word | input | 30 | Run-time frame format and bit time |
| line_in | input | 1 | Asynchronous serial input, idle high |
| char_valid | output | 1 | One-cycle strobe for a received character |
| char_data | output | 8 | Received character, zero-extended |
| parity_err | output | 1 | Parity mismatch, valid with the strobe |
| frame_err | output | 1 | Stop bit sampled low, valid with the strobe |
| line_break | output | 1 | Line held low for a whole frame |
| line_sync | output | 1 | Re-timed copy of the serial input |

## Verification
The hardest case to reach is a setup change that lands mid-frame, because it must arrive after a start edge has been accepted and before the last stop sample. The bench reaches it by forking a frame driver alongside a timed process. That process rewrites the setup word three bit times into an 8-bit frame, switching to a 5-bit even-parity format.

The scoreboard then expects the old 8-bit decode for that frame and the new format for the frame after it. The warm-up rule is reached by sending a complete, well-formed frame directly after reset and confirming that no strobe appears.

// File: rtl/srx_pkg.sv
// Package srx_pkg
// Shared widths, the decoded frame-format record and the receiver state type.
// Assumes the 30-bit setup layout described in the brief.
package srx_pkg;

    localparam int SETUP_W = 30;
    localparam int CKS_W   = 24;
    localparam int CHAR_W  = 8;
    localparam int NBITS_W = $clog2(CHAR_W + 1);

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_SPACE = 2'b10,
        PAR_MARK  = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic [CKS_W-1:0]   cks;
        logic [NBITS_W-1:0] nbits;
        logic               two_stop;
        logic               par_en;
        par_mode_e          pmode;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_WARM,
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_BREAK
    } rx_state_e;

    // Turn the raw setup word into a frame-format record
    function automatic frame_cfg_t decode_setup(input logic [SETUP_W-1:0] w);
        frame_cfg_t c;
        c.cks      = w[CKS_W-1:0];
        c.nbits    = NBITS_W'(CHAR_W) - NBITS_W'(w[29:28]);
        c.two_stop = w[27];
        c.par_en   = w[26];
        c.pmode    = par_mode_e'(w[25:24]);
        return c;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
// Module rx_line_sync
// Re-times the asynchronous serial input through a chain of STAGES flops.
// It also keeps one extra delayed copy so that edges can be detected.
// All flops reset to 1, the idle level of the line.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dsync,
    output logic dprev
);

    logic [STAGES-1:0] stg;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage: capture the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= 1'b1;
                    else        stg[0] <= din;
                end
            end else begin : g_next
                // Later stages: resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= 1'b1;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    // Previous value of the re-timed line, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) dprev <= 1'b1;
        else        dprev <= stg[STAGES-1];
    end

    assign dsync = stg[STAGES-1];

endmodule

// File: rtl/rx_baud_timer.sv
// Module rx_baud_timer
// Free-running bit-time counter that is cleared on request.
// Flags the half-bit point and the full-bit point, both measured from the last clear.
// Assumes cks >= 2.
module rx_baud_timer #(
    parameter int CKS_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CKS_W-1:0] cks,
    output logic             mid_tick,
    output logic             full_tick
);

    logic [CKS_W-1:0] cnt;
    logic [CKS_W-1:0] full_m1;
    logic [CKS_W-1:0] half_m1;

    // Terminal counts for the half and full bit time
    always_comb begin
        full_m1 = cks - CKS_W'(1);
        half_m1 = (cks >> 1) - CKS_W'(1);
    end

    assign full_tick = (cnt == full_m1);
    assign mid_tick  = (cnt == half_m1);

    // Count clocks, wrapping at the end of each bit time
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (full_tick)    cnt <= '0;
        else                   cnt <= cnt + CKS_W'(1);
    end

endmodule

// File: rtl/rx_idle_guard.sv
// Module rx_idle_guard
// While armed, counts consecutive bit times in which the line stays high.
// Any low sample, or dropping the arm input, starts the count again.
// 'ready' is raised once IDLE_BAUDS full bit times have been seen.
module rx_idle_guard #(
    parameter int CKS_W      = 24,
    parameter int IDLE_BAUDS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             line,
    input  logic [CKS_W-1:0] cks,
    output logic             ready
);

    localparam int BC_W = $clog2(IDLE_BAUDS + 1);

    logic [CKS_W-1:0] clk_cnt;
    logic [BC_W-1:0]  baud_cnt;
    logic             wrap;

    assign wrap  = (clk_cnt == cks - CKS_W'(1));
    assign ready = (baud_cnt == BC_W'(IDLE_BAUDS));

    // Measure uninterrupted high time in whole bit periods
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !line) begin
            clk_cnt  <= '0;
            baud_cnt <= '0;
        end else if (wrap) begin
            clk_cnt <= '0;
            if (!ready) baud_cnt <= baud_cnt + BC_W'(1);
        end else begin
            clk_cnt <= clk_cnt + CKS_W'(1);
        end
    end

endmodule

// File: rtl/rx_frame_ctrl.sv
// Module rx_frame_ctrl
// Frame sequencer. It captures the setup word while waiting for a start edge,
// confirms the start at half a bit time, then collects data bits least-significant
// first, the optional parity bit and the stop bits at their centres.
// It reports a character, or a line break, from that sequence.
// Assumes 'line' is already re-timed and 'line_prev' is its one-cycle-old copy.
module rx_frame_ctrl
    import srx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] setup_word,
    input  logic               line,
    input  logic               line_prev,
    input  logic               mid_tick,
    input  logic               full_tick,
    input  logic               warm_done,
    output logic               timer_restart,
    output logic               in_warmup,
    output logic [CKS_W-1:0]   cur_cks,
    output logic               char_valid,
    output logic [CHAR_W-1:0]  char_data,
    output logic               parity_err,
    output logic               frame_err,
    output logic               line_break
);

    rx_state_e          state;
    frame_cfg_t         cfg;
    logic [NBITS_W-1:0] bit_idx;
    logic [CHAR_W-1:0]  shreg;
    logic               all_low;
    logic               perr_acc;
    logic               ferr_acc;
    logic               exp_par;
    logic               last_bit;
    logic               start_edge;
    logic [CHAR_W-1:0]  aligned;

    assign cur_cks    = cfg.cks;
    assign in_warmup  = (state == ST_WARM);
    assign start_edge = line_prev && !line;
    assign last_bit   = (bit_idx == cfg.nbits - NBITS_W'(1));
    assign aligned    = shreg >> (NBITS_W'(CHAR_W) - cfg.nbits);

    // Hold the bit timer at zero except while a frame is being timed
    always_comb begin
        timer_restart = (state == ST_WARM) || (state == ST_IDLE) ||
                        (state == ST_BREAK) || ((state == ST_START) && mid_tick);
    end

    // Expected parity bit from the data collected so far (unused bits are zero)
    always_comb begin
        unique case (cfg.pmode)
            PAR_ODD:   exp_par = ~(^shreg);
            PAR_EVEN:  exp_par = ^shreg;
            PAR_SPACE: exp_par = 1'b0;
            default:   exp_par = 1'b1;
        endcase
    end

    // Frame sequencing and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WARM;
            cfg        <= decode_setup(setup_word);
            bit_idx    <= '0;
            shreg      <= '0;
            all_low    <= 1'b1;
            perr_acc   <= 1'b0;
            ferr_acc   <= 1'b0;
            char_valid <= 1'b0;
            char_data  <= '0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            line_break <= 1'b0;
        end else begin
            char_valid <= 1'b0;
            unique case (state)
                ST_WARM: begin
                    cfg <= decode_setup(setup_word);
                    if (warm_done) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    cfg <= decode_setup(setup_word);
                    if (start_edge) begin
                        state    <= ST_START;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        all_low  <= 1'b1;
                        perr_acc <= 1'b0;
                        ferr_acc <= 1'b0;
                    end
                end
                ST_START: begin
                    if (mid_tick) state <= line ? ST_IDLE : ST_DATA;
                end
                ST_DATA: begin
                    if (full_tick) begin
                        shreg   <= {line, shreg[CHAR_W-1:1]};
                        all_low <= all_low && !line;
                        bit_idx <= bit_idx + NBITS_W'(1);
                        if (last_bit) state <= cfg.par_en ? ST_PAR : ST_STOP1;
                    end
                end
                ST_PAR: begin
                    if (full_tick) begin
                        all_low  <= all_low && !line;
                        perr_acc <= (line != exp_par);
                        state    <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (full_tick) begin
                        if (all_low && !line) begin
                            state      <= ST_BREAK;
                            line_break <= 1'b1;
                        end else if (cfg.two_stop) begin
                            ferr_acc <= !line;
                            state    <= ST_STOP2;
                        end else begin
                            char_valid <= 1'b1;
                            char_data  <= aligned;
                            parity_err <= perr_acc;
                            frame_err  <= !line;
                            state      <= ST_IDLE;
                        end
                    end
                end
                ST_STOP2: begin
                    if (full_tick) begin
                        char_valid <= 1'b1;
                        char_data  <= aligned;
                        parity_err <= perr_acc;
                        frame_err  <= ferr_acc || !line;
                        state      <= ST_IDLE;
                    end
                end
                default: begin
                    if (line) begin
                        line_break <= 1'b0;
                        state      <= ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_rx_core.sv
// Module serial_rx_core
// Top level of the configurable asynchronous serial receiver. It joins the
// line synchroniser, the bit timer, the post-reset idle guard and the frame sequencer.
// Assumes a synchronous active-low reset and a clocks-per-bit value of at least 2.
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_BAUDS  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] setup_word,
    input  logic               line_in,
    output logic               char_valid,
    output logic [CHAR_W-1:0]  char_data,
    output logic               parity_err,
    output logic               frame_err,
    output logic               line_break,
    output logic               line_sync
);

    logic             s_line;
    logic             s_prev;
    logic             t_restart;
    logic             t_mid;
    logic             t_full;
    logic             g_ready;
    logic             warm;
    logic [CKS_W-1:0] cks_q;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .dsync (s_line),
        .dprev (s_prev)
    );

    rx_baud_timer #(.CKS_W(CKS_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (t_restart),
        .cks       (cks_q),
        .mid_tick  (t_mid),
        .full_tick (t_full)
    );

    rx_idle_guard #(.CKS_W(CKS_W), .IDLE_BAUDS(IDLE_BAUDS)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (warm),
        .line  (s_line),
        .cks   (cks_q),
        .ready (g_ready)
    );

    rx_frame_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .setup_word    (setup_word),
        .line          (s_line),
        .line_prev     (s_prev),
        .mid_tick      (t_mid),
        .full_tick     (t_full),
        .warm_done     (g_ready),
        .timer_restart (t_restart),
        .in_warmup     (warm),
        .cur_cks       (cks_q),
        .char_valid    (char_valid),
        .char_data     (char_data),
        .parity_err    (parity_err),
        .frame_err     (frame_err),
        .line_break    (line_break)
    );

    assign line_sync = s_line;

endmodule

// File: rtl/srx_checker.sv
// Module srx_checker
// Property checks on the receiver ports, attached to serial_rx_core through bind.
module srx_checker (
    input logic clk,
    input logic rst_n,
    input logic line_in,
    input logic line_sync,
    input logic char_valid,
    input logic line_break
);

    logic [1:0] since_rst;

    // Count clock edges since reset was released, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
    end

    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (line_sync == $past(line_in, 2)));

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    assert_break_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |-> !char_valid);

    assert_break_rise_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_break) |-> !$past(line_sync));

    assert_break_fall_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_break) |-> $past(line_sync));

endmodule

bind serial_rx_core srx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .line_sync  (line_sync),
    .char_valid (char_valid),
    .line_break (line_break)
);

// File: tb/tb_serial_rx_core.sv
// Scoreboard bench for serial_rx_core. A driver task builds frames and queues
// the expected result of each one. A monitor on the falling clock edge pops
// the queue and compares it with every strobe the receiver produces.
module tb_serial_rx_core;

    localparam int CKS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] setup_word;
    logic        line_in = 1'b1;
    logic        char_valid;
    logic [7:0]  char_data;
    logic        parity_err;
    logic        frame_err;
    logic        line_break;
    logic        line_sync;

    int n_checks  = 0;
    int n_fail    = 0;
    int n_strobes = 0;
    bit finished  = 0;
    bit prev_valid = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    serial_rx_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_word (setup_word),
        .line_in    (line_in),
        .char_valid (char_valid),
        .char_data  (char_data),
        .parity_err (parity_err),
        .frame_err  (frame_err),
        .line_break (line_break),
        .line_sync  (line_sync)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [29:0] mk_setup(input int nbits, input bit two,
                                             input bit pen, input bit fx, input bit t);
        logic [1:0] code;
        code = 2'(8 - nbits);
        return {code, two, pen, fx, t, 24'(CKS)};
    endfunction

    // Monitor: compare every strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) check(!char_valid, "R7", "strobe width", char_valid, 0);
            prev_valid = char_valid;
            if (char_valid) begin
                n_strobes++;
                if (exp_q.size() == 0) begin
                    check(0, "R9/R10/R11", "unexpected strobe", char_data, 0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(char_data == e[7:0], t, "data", char_data, e[7:0]);
                    check(parity_err == e[8], t, "parity_err", parity_err, e[8]);
                    check(frame_err == e[9], t, "frame_err", frame_err, e[9]);
                end
            end
        end
    end

    task automatic put(input logic v, input int n);
        line_in = v;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: send one frame and, if a strobe is due, queue its expected result
    task automatic send_frame(input logic [7:0] data, input int nbits, input bit two,
                              input bit pen, input bit fx, input bit t,
                              input bit bad_par, input bit stop1_low,
                              input bit stop2_low, input bit expect_it,
                              input string tag);
        logic [7:0] mask;
        logic       pb;
        mask = 8'hFF >> (8 - nbits);
        if (fx)     pb = t;
        else if (t) pb = ^(data & mask);
        else        pb = ~(^(data & mask));
        if (bad_par) pb = ~pb;
        if (expect_it) begin
            exp_q.push_back({stop1_low | (two & stop2_low), pen & bad_par, data & mask});
            tag_q.push_back(tag);
        end
        put(1'b0, CKS);
        for (int i = 0; i < nbits; i++) put(data[i], CKS);
        if (pen) put(pb, CKS);
        put(!stop1_low, CKS);
        if (two) put(!stop2_low, CKS);
        put(1'b1, 2 * CKS);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s0;
        setup_word = mk_setup(8, 0, 0, 0, 0);
        repeat (5) @(posedge clk);
        #1;
        check(char_valid == 0, "R1", "char_valid in reset", char_valid, 0);
        check(line_break == 0, "R1", "line_break in reset", line_break, 0);
        check(line_sync == 1, "R1", "line_sync in reset", line_sync, 1);
        rst_n = 1'b1;

        // R9: a full frame right after reset must be ignored
        put(1'b1, 3 * CKS);
        send_frame(8'h55, 8, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        check(n_strobes == 0, "R9", "strobe during warm-up", n_strobes, 0);
        put(1'b1, 20 * CKS);
        send_frame(8'h81, 8, 0, 0, 0, 0, 0, 0, 0, 1, "R9");

        // R3: 8 data bits, no parity, one stop bit
        send_frame(8'hA5, 8, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
        send_frame(8'h3C, 8, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
        send_frame(8'h00, 8, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
        send_frame(8'hFF, 8, 0, 0, 0, 0, 0, 0, 0, 1, "R3");

        // R4: shorter words
        setup_word = mk_setup(7, 0, 0, 0, 0);
        send_frame(8'hDA, 7, 0, 0, 0, 0, 0, 0, 0, 1, "R4");
        setup_word = mk_setup(6, 0, 0, 0, 0);
        send_frame(8'h2B, 6, 0, 0, 0, 0, 0, 0, 0, 1, "R4");
        setup_word = mk_setup(5, 0, 0, 0, 0);
        send_frame(8'hF3, 5, 0, 0, 0, 0, 0, 0, 0, 1, "R4");

        // R5: parity modes, good and bad
        setup_word = mk_setup(8, 0, 1, 0, 0);
        send_frame(8'h71, 8, 0, 1, 0, 0, 0, 0, 0, 1, "R5");
        send_frame(8'h70, 8, 0, 1, 0, 0, 1, 0, 0, 1, "R5");
        setup_word = mk_setup(8, 0, 1, 0, 1);
        send_frame(8'h71, 8, 0, 1, 0, 1, 0, 0, 0, 1, "R5");
        send_frame(8'h13, 8, 0, 1, 0, 1, 1, 0, 0, 1, "R5");
        setup_word = mk_setup(7, 0, 1, 1, 0);
        send_frame(8'h4E, 7, 0, 1, 1, 0, 0, 0, 0, 1, "R5");
        setup_word = mk_setup(8, 0, 1, 1, 1);
        send_frame(8'h2E, 8, 0, 1, 1, 1, 0, 0, 0, 1, "R5");
        send_frame(8'h2F, 8, 0, 1, 1, 1, 1, 0, 0, 1, "R5");

        // R6: framing errors, one and two stop bits
        setup_word = mk_setup(8, 0, 0, 0, 0);
        send_frame(8'h6D, 8, 0, 0, 0, 0, 0, 1, 0, 1, "R6");
        setup_word = mk_setup(8, 1, 0, 0, 0);
        send_frame(8'hC3, 8, 1, 0, 0, 0, 0, 0, 0, 1, "R6");
        send_frame(8'h5A, 8, 1, 0, 0, 0, 0, 0, 1, 1, "R6");

        // R8: setup change in the middle of a frame
        setup_word = mk_setup(8, 0, 0, 0, 0);
        put(1'b1, CKS);
        fork
            send_frame(8'h96, 8, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
            begin
                repeat (3 * CKS) @(posedge clk);
                setup_word = mk_setup(5, 0, 1, 0, 1);
            end
        join
        send_frame(8'h0B, 5, 0, 1, 0, 1, 0, 0, 0, 1, "R8");
        setup_word = mk_setup(8, 0, 0, 0, 0);
        put(1'b1, CKS);

        // R10: short low pulse is discarded
        s0 = n_strobes;
        put(1'b0, 4);
        put(1'b1, 2 * CKS);
        check(n_strobes == s0, "R10", "strobe after glitch", n_strobes, s0);
        send_frame(8'hE7, 8, 0, 0, 0, 0, 0, 0, 0, 1, "R10");

        // R2 and R11: two-edge delay on line_sync, then a line break
        s0 = n_strobes;
        line_in = 1'b0;
        @(posedge clk); #1;
        check(line_sync == 1, "R2", "line_sync after one edge", line_sync, 1);
        @(posedge clk); #1;
        check(line_sync == 0, "R2", "line_sync after two edges", line_sync, 0);
        put(1'b0, 12 * CKS);
        check(line_break == 1, "R11", "line_break while held low", line_break, 1);
        check(n_strobes == s0, "R11", "strobe on break", n_strobes, s0);
        put(1'b1, CKS);
        check(line_break == 0, "R11", "line_break after release", line_break, 0);
        send_frame(8'h42, 8, 0, 0, 0, 0, 0, 0, 0, 1, "R11");

        put(1'b1, 2 * CKS);
        check(exp_q.size() == 0, "R3", "missing strobes", exp_q.size(), 0);
        finish_run();
    end

endmodule